// File: doc/BRIEF.md
# Dual-Register Serial Synthesiser Loader

This block is the load path for a device that keeps two independent synthesiser control words. A host drives three lines: a serial clock, a serial data line and an enable. The clock and data lines may be shared with other devices. The enable line belongs to this device alone. While enable is high, the block shifts in one transmission, most significant bit first. When enable falls, it judges the word by its bit count and by its lowest bit. It then writes the word into one of the two control registers, or it drops the word.

The lowest bit of every word is the register address: 0 selects loop 1 and 1 selects loop 2. Each word carries that loop's divider ratio and charge-pump current. The loop-2 word also carries the shared reference-divider select, two port data bits and a test-enable bit. A loop-2 word may be two bits longer than usual. Those extra leading bits are the test-select code, and a short word leaves that code at zero.

Two switching ports stay undriven until the first valid loop-2 write. After that they show either the programmed port data or, in test mode, the test-select code. Both serial inputs and the enable are brought into the system clock domain before use.

Top module: `dual_synth_loader`

## Requirements
- R1: After reset, every decoded field, `test_mode`, `test_sel`, `port_out` and `port_oe` read zero.
- R2: Serial clock pulses while `ser_en` is low change no output and do not disturb the bit count of the next transmission.
- R3: Bits are taken on rising serial clock edges, most significant first, and the last bit received (word bit 0) is the address: 0 writes loop 1 and 1 writes loop 2. The register that is not addressed keeps its contents.
- R4: Word fields by bit position: ratio in bits 12..1, charge-pump current in bits 14..13, reference select in 16..15, port data in 18..17, test enable in bit 19. A loop-1 word ignores bits 19..15.
- R5: A 20-bit loop-2 word sets `test_sel` to 0. Whenever `test_mode` is 0, `test_sel` reads 0.
- R6: A 22-bit loop-2 word carries the test-select code in bits 21..20. That code reaches `test_sel` only when bit 19 is 1, and bit 19 drives `test_mode`.
- R7: A transmission is dropped, leaving both registers unchanged, when its length is anything other than 20 bits or a 22-bit loop-2 word. A 22-bit loop-1 word is also dropped.
- R8: `port_oe` stays low until the first accepted loop-2 word and then stays high until reset.
- R9: `port_out` equals `test_sel` when `test_mode` is 1, and the port data bits otherwise.
- R10: The registers change only when enable falls. Bits still being shifted in have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bus clock, asynchronous |
| ser_data | input | 1 | Serial bus data, asynchronous |
| ser_en | input | 1 | Device enable, active high, asynchronous |
| s1_ratio | output | 12 | Loop 1 divider ratio |
| s1_cp | output | 2 | Loop 1 charge-pump current code |
| s2_ratio | output | 12 | Loop 2 divider ratio |
| s2_cp | output | 2 | Loop 2 charge-pump current code |
| ref_sel | output | 2 | Shared reference-divider select |
| test_mode | output | 1 | Test enable bit from the loop-2 word |
| test_sel | output | 2 | Test-select code, zero outside test mode |
| port_out | output | 2 | Switching port data |
| port_oe | output | 1 | Switching port output enable |

## Verification
The checker assumes that the serial data line is steady while a serial clock rise passes through the synchronisers. It also assumes that each serial level lasts several system clocks, so that no edge is lost and enable never moves in the same cycle as a clock rise. The bench holds each serial level for four system clocks. It changes data only while the serial clock is low, and it raises enable at least four clocks before the first bit. Under those conditions, the register-hold and single-verdict properties follow from the decoder alone.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

  typedef enum logic [1:0] {
    FR_DROP = 2'd0,
    FR_S1   = 2'd1,
    FR_S2   = 2'd2
  } verdict_e;

  // Length of the short word: address, ratio, pump, reference, port data, test bit.
  function automatic int unsigned short_len(input int unsigned div_w,
                                            input int unsigned cp_w,
                                            input int unsigned ref_w,
                                            input int unsigned port_n);
    return 1 + div_w + cp_w + ref_w + port_n + 1;
  endfunction

  // Judge a finished frame from its bit count and its address bit.
  function automatic verdict_e classify(input int unsigned cnt,
                                        input logic        addr,
                                        input int unsigned s_len,
                                        input int unsigned l_len);
    if (cnt == s_len) return addr ? FR_S2 : FR_S1;
    if (cnt == l_len && addr) return FR_S2;
    return FR_DROP;
  endfunction

endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] st1, st2, st3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= '0;
      st2 <= '0;
      st3 <= '0;
    end else begin
      st1 <= async_in;
      st2 <= st1;
      st3 <= st2;
    end
  end

  assign lvl = st2;
  assign chg = st2 ^ st3;
endmodule

// File: rtl/dsl_shifter.sv
module dsl_shifter #(
  parameter int LONG_LEN = 22,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_lvl,
  input  logic                en_rise,
  input  logic                sclk_rise,
  input  logic                sdata,
  output logic [LONG_LEN-1:0] word,
  output logic [CNT_W-1:0]    bit_cnt,
  output logic                bit_strobe
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign bit_strobe = sclk_rise && en_lvl && !en_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (en_rise) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (bit_strobe) begin
      word <= {word[LONG_LEN-2:0], sdata};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dsl_regs.sv
module dsl_regs
  import dsl_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int CP_W     = 2,
  parameter int REF_W    = 2,
  parameter int PORT_N   = 2,
  parameter int LONG_LEN = 22,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end,
  input  logic [LONG_LEN-1:0] word,
  input  logic [CNT_W-1:0]    bit_cnt,
  output logic                commit_s1,
  output logic                commit_s2,
  output logic                discard,
  output logic [DIV_W-1:0]    s1_ratio,
  output logic [CP_W-1:0]     s1_cp,
  output logic [DIV_W-1:0]    s2_ratio,
  output logic [CP_W-1:0]     s2_cp,
  output logic [REF_W-1:0]    ref_sel,
  output logic                test_mode,
  output logic [PORT_N-1:0]   test_sel,
  output logic [PORT_N-1:0]   port_out,
  output logic                port_oe
);
  localparam int RAT_LO   = 1;
  localparam int CP_LO    = RAT_LO + DIV_W;
  localparam int REF_LO   = CP_LO + CP_W;
  localparam int PD_LO    = REF_LO + REF_W;
  localparam int T0_POS   = PD_LO + PORT_N;
  localparam int TS_LO    = T0_POS + 1;
  localparam int S_LEN    = int'(short_len(DIV_W, CP_W, REF_W, PORT_N));

  verdict_e            verdict;
  logic [PORT_N-1:0]   pdata_q;

  always_comb begin
    verdict = classify(32'(bit_cnt), word[0], S_LEN, LONG_LEN);
  end

  assign commit_s1 = frame_end && (verdict == FR_S1);
  assign commit_s2 = frame_end && (verdict == FR_S2);
  assign discard   = frame_end && (verdict == FR_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ratio <= '0;
      s1_cp    <= '0;
    end else if (commit_s1) begin
      s1_ratio <= word[RAT_LO +: DIV_W];
      s1_cp    <= word[CP_LO +: CP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_ratio  <= '0;
      s2_cp     <= '0;
      ref_sel   <= '0;
      pdata_q   <= '0;
      test_mode <= 1'b0;
      test_sel  <= '0;
      port_oe   <= 1'b0;
    end else if (commit_s2) begin
      s2_ratio  <= word[RAT_LO +: DIV_W];
      s2_cp     <= word[CP_LO +: CP_W];
      ref_sel   <= word[REF_LO +: REF_W];
      pdata_q   <= word[PD_LO +: PORT_N];
      test_mode <= word[T0_POS];
      test_sel  <= word[T0_POS] ? word[TS_LO +: PORT_N] : '0;
      port_oe   <= 1'b1;
    end
  end

  assign port_out = test_mode ? test_sel : pdata_q;
endmodule

// File: rtl/dual_synth_loader.sv
module dual_synth_loader
  import dsl_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int CP_W   = 2,
  parameter int REF_W  = 2,
  parameter int PORT_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en,
  output logic [DIV_W-1:0]  s1_ratio,
  output logic [CP_W-1:0]   s1_cp,
  output logic [DIV_W-1:0]  s2_ratio,
  output logic [CP_W-1:0]   s2_cp,
  output logic [REF_W-1:0]  ref_sel,
  output logic              test_mode,
  output logic [PORT_N-1:0] test_sel,
  output logic [PORT_N-1:0] port_out,
  output logic              port_oe
);
  localparam int S_LEN    = int'(short_len(DIV_W, CP_W, REF_W, PORT_N));
  localparam int LONG_LEN = S_LEN + PORT_N;
  localparam int CNT_W    = $clog2(LONG_LEN + 2);

  logic [2:0]          sy_lvl, sy_chg;
  logic                en_lvl, en_rise, frame_end, sclk_rise, sdata, data_chg;
  logic [LONG_LEN-1:0] word;
  logic [CNT_W-1:0]    bit_cnt;
  logic                bit_strobe;
  logic                commit_s1, commit_s2, discard;

  dsl_sync #(.W(3)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_en, ser_clk, ser_data}),
    .lvl      (sy_lvl),
    .chg      (sy_chg)
  );

  assign sdata     = sy_lvl[0];
  assign data_chg  = sy_chg[0];
  assign sclk_rise = sy_chg[1] && sy_lvl[1];
  assign en_lvl    = sy_lvl[2];
  assign en_rise   = sy_chg[2] && sy_lvl[2];
  assign frame_end = sy_chg[2] && !sy_lvl[2];

  dsl_shifter #(.LONG_LEN(LONG_LEN), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_lvl     (en_lvl),
    .en_rise    (en_rise),
    .sclk_rise  (sclk_rise),
    .sdata      (sdata),
    .word       (word),
    .bit_cnt    (bit_cnt),
    .bit_strobe (bit_strobe)
  );

  dsl_regs #(
    .DIV_W(DIV_W), .CP_W(CP_W), .REF_W(REF_W), .PORT_N(PORT_N),
    .LONG_LEN(LONG_LEN), .CNT_W(CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .word      (word),
    .bit_cnt   (bit_cnt),
    .commit_s1 (commit_s1),
    .commit_s2 (commit_s2),
    .discard   (discard),
    .s1_ratio  (s1_ratio),
    .s1_cp     (s1_cp),
    .s2_ratio  (s2_ratio),
    .s2_cp     (s2_cp),
    .ref_sel   (ref_sel),
    .test_mode (test_mode),
    .test_sel  (test_sel),
    .port_out  (port_out),
    .port_oe   (port_oe)
  );
endmodule

// File: rtl/dsl_checker.sv
module dsl_checker #(
  parameter int DIV_W  = 12,
  parameter int CP_W   = 2,
  parameter int REF_W  = 2,
  parameter int PORT_N = 2,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_lvl,
  input logic              sclk_rise,
  input logic              data_chg,
  input logic              bit_strobe,
  input logic              frame_end,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              commit_s1,
  input logic              commit_s2,
  input logic              discard,
  input logic [DIV_W-1:0]  s1_ratio,
  input logic [CP_W-1:0]   s1_cp,
  input logic [DIV_W-1:0]  s2_ratio,
  input logic [REF_W-1:0]  ref_sel,
  input logic              test_mode,
  input logic [PORT_N-1:0] test_sel,
  input logic              port_oe
);
  // R3 (input assumption: data steady at a sampled clock rise)
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |-> !data_chg);

  // R2
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lvl |=> $stable(bit_cnt));

  // R2
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lvl |-> !bit_strobe);

  // R10
  verdict_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_s1 || commit_s2 || discard) |-> frame_end);

  // R7
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $countones({commit_s1, commit_s2, discard}) == 1);

  // R10
  s1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_s1 |=> $stable(s1_ratio) && $stable(s1_cp));

  // R10
  s2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_s2 |=> $stable(s2_ratio) && $stable(ref_sel) && $stable(test_mode));

  // R5
  idle_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> test_sel == '0);

  // R8
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_oe |=> port_oe);

  // R8
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_oe) |-> $past(commit_s2));
endmodule

bind dual_synth_loader dsl_checker #(
  .DIV_W(DIV_W), .CP_W(CP_W), .REF_W(REF_W), .PORT_N(PORT_N), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_lvl     (en_lvl),
  .sclk_rise  (sclk_rise),
  .data_chg   (data_chg),
  .bit_strobe (bit_strobe),
  .frame_end  (frame_end),
  .bit_cnt    (bit_cnt),
  .commit_s1  (commit_s1),
  .commit_s2  (commit_s2),
  .discard    (discard),
  .s1_ratio   (s1_ratio),
  .s1_cp      (s1_cp),
  .s2_ratio   (s2_ratio),
  .ref_sel    (ref_sel),
  .test_mode  (test_mode),
  .test_sel   (test_sel),
  .port_oe    (port_oe)
);

// File: tb/dual_synth_loader_bench.sv
module dual_synth_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SER_HALF   = 4;
  localparam int NV         = 9;

  // {length[4:0], word[21:0]}
  localparam logic [26:0] VECS [0:NV-1] = '{
    {5'd20, 22'h0FD578},  // loop 1, junk in ignored bits
    {5'd20, 22'h05A247},  // loop 2 short
    {5'd22, 22'h3A61FF},  // loop 2 long, test on, code 3
    {5'd22, 22'h129001},  // loop 2 long, test off
    {5'd22, 22'h3FFFFE},  // loop 1 long: dropped
    {5'd19, 22'h000001},  // too short: dropped
    {5'd21, 22'h0AAAAB},  // odd length: dropped
    {5'd20, 22'h002002},  // loop 1 short
    {5'd22, 22'h2C0001}   // loop 2 long, test on, code 2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic [11:0] s1_ratio, s2_ratio;
  logic [1:0]  s1_cp, s2_cp, ref_sel, test_sel, port_out;
  logic        test_mode, port_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [11:0] e_s1_ratio = '0, e_s2_ratio = '0;
  logic [1:0]  e_s1_cp = '0, e_s2_cp = '0, e_ref = '0, e_tsel = '0, e_pd = '0;
  logic        e_tm = 1'b0, e_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_synth_loader u_dual_synth_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .s1_ratio(s1_ratio), .s1_cp(s1_cp), .s2_ratio(s2_ratio), .s2_cp(s2_cp),
    .ref_sel(ref_sel), .test_mode(test_mode), .test_sel(test_sel),
    .port_out(port_out), .port_oe(port_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk(req, "s1_ratio", int'(s1_ratio), int'(e_s1_ratio));
    chk(req, "s1_cp", int'(s1_cp), int'(e_s1_cp));
    chk(req, "s2_ratio", int'(s2_ratio), int'(e_s2_ratio));
    chk(req, "s2_cp", int'(s2_cp), int'(e_s2_cp));
    chk(req, "ref_sel", int'(ref_sel), int'(e_ref));
    chk(req, "test_mode", int'(test_mode), int'(e_tm));
    chk(req, "test_sel", int'(test_sel), int'(e_tsel));
    chk(req, "port_oe", int'(port_oe), int'(e_oe));
    chk(req, "port_out", int'(port_out), e_tm ? int'(e_tsel) : int'(e_pd));
  endtask

  // Bench-side model of acceptance and field extraction.
  task automatic model(input int len, input logic [21:0] w);
    logic [21:0] sh;
    if (!(len == 20 || (len == 22 && w[0] == 1'b1))) return;
    sh = w >> 1;
    if (w[0] == 1'b0) begin
      e_s1_ratio = sh[11:0];
      e_s1_cp    = sh[13:12];
    end else begin
      e_s2_ratio = sh[11:0];
      e_s2_cp    = sh[13:12];
      e_ref      = sh[15:14];
      e_pd       = sh[17:16];
      e_tm       = sh[18];
      e_tsel     = (sh[18] && len == 22) ? sh[20:19] : 2'b00;
      e_oe       = 1'b1;
    end
  endtask

  task automatic shift_bits(input int len, input logic [21:0] w);
    for (int i = len - 1; i >= 0; i--) begin
      ser_data = (i < 22) ? w[i] : 1'b0;
      wait_sys(SER_HALF);
      ser_clk = 1'b1;
      wait_sys(SER_HALF);
      ser_clk = 1'b0;
    end
  endtask

  task automatic send(input int len, input logic [21:0] w);
    ser_en = 1'b1;
    wait_sys(SER_HALF);
    shift_bits(len, w);
    wait_sys(SER_HALF);
    ser_en = 1'b0;
    wait_sys(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_sys(3);
    // R1 reset state while held and after release
    check_all("R1");
    rst_n = 1'b1;
    wait_sys(3);
    check_all("R1");

    for (int v = 0; v < NV; v++) begin
      send(int'(VECS[v][26:22]), VECS[v][21:0]);
      model(int'(VECS[v][26:22]), VECS[v][21:0]);
      // R3 R4 R5 R6 R7 R8 R9 routing, fields, test code, drop rules, ports
      check_all("R3/R4/R6/R7/R9");
    end

    // R2: clock and data toggling with enable low
    for (int k = 0; k < 21; k++) begin
      ser_data = 1'b1;
      wait_sys(SER_HALF);
      ser_clk = 1'b1;
      wait_sys(SER_HALF);
      ser_clk = 1'b0;
    end
    wait_sys(8);
    check_all("R2");
    send(20, 22'h0A5554);
    model(20, 22'h0A5554);
    check_all("R2");

    // R10: outputs unchanged mid-frame; R7: truncated frame then dropped
    ser_en = 1'b1;
    wait_sys(SER_HALF);
    shift_bits(10, 22'h3FF);
    wait_sys(4);
    check_all("R10");
    ser_en = 1'b0;
    wait_sys(8);
    check_all("R7");

    // R7: overlong frame dropped
    send(30, 22'h000003);
    check_all("R7");

    // R8: reset clears port enable, loop-1 write does not set it
    rst_n = 1'b0;
    wait_sys(2);
    rst_n = 1'b1;
    e_s1_ratio = '0; e_s2_ratio = '0; e_s1_cp = '0; e_s2_cp = '0;
    e_ref = '0; e_tsel = '0; e_pd = '0; e_tm = 1'b0; e_oe = 1'b0;
    wait_sys(3);
    check_all("R1");
    send(20, 22'h002002);
    model(20, 22'h002002);
    chk("R8", "port_oe after loop-1 write", int'(port_oe), 0);
    send(20, 22'h060001);
    model(20, 22'h060001);
    chk("R8", "port_oe after loop-2 write", int'(port_oe), 1);
    // R9 port data with test off
    chk("R9", "port_out", int'(port_out), 3);
    // R5 short loop-2 word with test bit set gives code 0
    send(20, 22'h080001);
    model(20, 22'h080001);
    chk("R5", "test_mode", int'(test_mode), 1);
    chk("R5", "test_sel", int'(test_sel), 0);
    check_all("R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule